// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital sequencing logic of a successive-approximation converter. A start request taken while idle clears the approximation register. Then, once per clock, one bit is tried, from the top bit downward. The trial code goes to an external DAC. An external comparator answers with one bit for each trial, and that answer decides whether the bit under test is kept or dropped.

A mode input selects a full 12-bit conversion or a shortened 8-bit conversion. The 8-bit conversion stops after the upper eight bits have been decided. A busy flag stays high for the whole conversion, and the same flag gates the conversion clock. When the last bit is decided, busy falls and a one-cycle done pulse is raised.

The finished code is read through a gated read port. The port has a chip enable and a byte select. Output enable is refused for as long as a conversion is running. Unipolar and bipolar codes pass through unchanged.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After synchronous reset, `busy_o`, `done_o` and `conv_clk_en_o` are 0, and `trial_o` is all zeros.
- R2: A `start_i` sampled high while idle is accepted. In the next cycle `busy_o` is 1 and the register holds zero, so `trial_o` equals 12'h800.
- R3: In trial cycle k (k = 0 for the first cycle after acceptance), `trial_o` is the bits already decided above position 11-k, with bit 11-k set and all lower bits zero.
- R4: At the end of each trial the tested bit is kept when `comp_below_i` is 1 (DAC sum below input) and cleared when it is 0.
- R5: `start_i` while `busy_o` is high is ignored. The running conversion keeps its length and its result.
- R6: In 12-bit mode (`short_i` = 0 at acceptance), `busy_o` is high for exactly 12 cycles. `done_o` is high for exactly one cycle, the first cycle with `busy_o` low.
- R7: In 8-bit mode (`short_i` = 1 at acceptance), `busy_o` is high for exactly 8 cycles and result bits [3:0] are zero.
- R8: While `busy_o` is high, `rd_oe_o` is 0 and `rd_data_o` is all zeros, whatever `chip_en_i` is.
- R9: When idle with `chip_en_i` = 1, `rd_oe_o` is 1. With `byte_sel_i` = 0, `rd_data_o` is the 12-bit result. With `byte_sel_i` = 1 it is {result[3:0], 8'h00}.
- R10: When idle with `chip_en_i` = 0, `rd_oe_o` is 0 and `rd_data_o` is zero.
- R11: The result equals the code the comparator answers define, with no recoding. With a comparator that keeps a bit while trial <= target, a 12-bit result equals the target, and an 8-bit result equals target & 12'hFF0.
- R12: A start presented in the cycle that `done_o` is high is accepted: the next cycle shows `busy_o` = 1 and `trial_o` = 12'h800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to start a conversion |
| short_i | input | 1 | 1 selects 8-bit mode, sampled at acceptance |
| comp_below_i | input | 1 | Comparator answer: 1 when DAC sum is below input |
| chip_en_i | input | 1 | Read port chip enable |
| byte_sel_i | input | 1 | 0 = full word, 1 = low nibble moved to top |
| trial_o | output | 12 | Trial code to the DAC |
| busy_o | output | 1 | Status, high during conversion |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| conv_clk_en_o | output | 1 | Conversion clock enable |
| rd_oe_o | output | 1 | Read data drive enable (0 = bus released) |
| rd_data_o | output | 12 | Read data, zero when not enabled |

## Verification
Two events can fall in the same cycle: the end-of-conversion done pulse and the acceptance of a new start. The bench drives `start_i` high in exactly the cycle where it sees `done_o` high. It then requires the following cycle to show a fresh conversion: busy high, trial code 12'h800, and a full trial count. The previous result must also still be readable in the done cycle itself. A start held during a running conversion is judged separately, by the conversion length and the result it leaves.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } conv_state_e;

  // Bit index at which a conversion ends for the selected length.
  function automatic int stop_index(input int width, input int short_bits, input logic short_mode);
    return short_mode ? (width - short_bits) : 0;
  endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8,
  localparam int IDXW      = $clog2(WIDTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            short_i,
  output logic            accept_o,
  output logic            busy_o,
  output logic            last_o,
  output logic            done_o,
  output logic            short_q_o,
  output logic [IDXW-1:0] idx_o
);
  import sar_conv_pkg::*;

  localparam logic [IDXW-1:0] TOP_IDX    = IDXW'(WIDTH - 1);
  localparam logic [IDXW-1:0] FULL_STOP  = IDXW'(stop_index(WIDTH, SHORT_BITS, 1'b0));
  localparam logic [IDXW-1:0] SHORT_STOP = IDXW'(stop_index(WIDTH, SHORT_BITS, 1'b1));

  conv_state_e     state_q;
  logic [IDXW-1:0] idx_q;
  logic            short_q;
  logic            done_q;
  logic [IDXW-1:0] stop_w;

  assign stop_w   = short_q ? SHORT_STOP : FULL_STOP;
  assign busy_o   = (state_q == ST_CONV);
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign last_o   = busy_o && (idx_q == stop_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      short_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_CONV;
            idx_q   <= TOP_IDX;
            short_q <= short_i;
          end
        end
        ST_CONV: begin
          if (last_o) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o    = done_q;
  assign short_q_o = short_q;
  assign idx_o     = idx_q;

endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int WIDTH = 12,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic             busy_i,
  input  logic [IDXW-1:0]  idx_i,
  input  logic             comp_below_i,
  output logic [WIDTH-1:0] sar_o,
  output logic [WIDTH-1:0] trial_o
);

  function automatic logic [WIDTH-1:0] bit_mask(input logic [IDXW-1:0] idx);
    return {{(WIDTH-1){1'b0}}, 1'b1} << idx;
  endfunction

  logic [WIDTH-1:0] sar_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sar_q <= '0;
    end else if (accept_i) begin
      sar_q <= '0;
    end else if (busy_i) begin
      sar_q[idx_i] <= comp_below_i;
    end
  end

  assign sar_o   = sar_q;
  assign trial_o = busy_i ? (sar_q | bit_mask(idx_i)) : sar_q;

endmodule

// File: rtl/sar_rdport.sv
module sar_rdport #(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8,
  localparam int LOW       = WIDTH - SHORT_BITS
) (
  input  logic             busy_i,
  input  logic             chip_en_i,
  input  logic             byte_sel_i,
  input  logic [WIDTH-1:0] sar_i,
  output logic             oe_o,
  output logic [WIDTH-1:0] data_o
);

  logic [WIDTH-1:0] alt_w;

  generate
    if (LOW > 0) begin : g_low
      assign alt_w = {sar_i[LOW-1:0], {(WIDTH-LOW){1'b0}}};
    end else begin : g_nolow
      assign alt_w = sar_i;
    end
  endgenerate

  assign oe_o   = chip_en_i && !busy_i;
  assign data_o = !oe_o ? '0 : (byte_sel_i ? alt_w : sar_i);

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             short_i,
  input  logic             comp_below_i,
  input  logic             chip_en_i,
  input  logic             byte_sel_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             conv_clk_en_o,
  output logic             rd_oe_o,
  output logic [WIDTH-1:0] rd_data_o
);
  localparam int IDXW = $clog2(WIDTH);

  logic            accept_w;
  logic            last_w;
  logic            short_q;
  logic [IDXW-1:0] idx_w;
  logic [WIDTH-1:0] sar_q;

  sar_seq #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) seq_i (
    .clk(clk), .rst(rst), .start_i(start_i), .short_i(short_i),
    .accept_o(accept_w), .busy_o(busy_o), .last_o(last_w),
    .done_o(done_o), .short_q_o(short_q), .idx_o(idx_w)
  );

  sar_reg #(.WIDTH(WIDTH)) reg_i (
    .clk(clk), .rst(rst), .accept_i(accept_w), .busy_i(busy_o),
    .idx_i(idx_w), .comp_below_i(comp_below_i),
    .sar_o(sar_q), .trial_o(trial_o)
  );

  sar_rdport #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) rd_i (
    .busy_i(busy_o), .chip_en_i(chip_en_i), .byte_sel_i(byte_sel_i),
    .sar_i(sar_q), .oe_o(rd_oe_o), .data_o(rd_data_o)
  );

  assign conv_clk_en_o = busy_o;

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             accept_w,
  input logic             last_w,
  input logic             short_q,
  input logic [WIDTH-1:0] sar_q,
  input logic             busy_o,
  input logic             done_o,
  input logic             rd_oe_o,
  input logic [WIDTH-1:0] rd_data_o
);
  localparam int LOW = WIDTH - SHORT_BITS;
  localparam logic [WIDTH-1:0] LOW_MASK = WIDTH'((64'd1 << LOW) - 64'd1);

  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> (busy_o && sar_q == '0)); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |-> !accept_w); // R5

  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !last_w) |=> busy_o); // R5

  AST_LAST_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
    last_w |=> (done_o && !busy_o)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

  AST_SHORT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busy_o && short_q) |-> ((sar_q & LOW_MASK) == '0)); // R7

  AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (!rd_oe_o && rd_data_o == '0)); // R8

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .accept_w(accept_w),
  .last_w(last_w), .short_q(short_q), .sar_q(sar_q), .busy_o(busy_o),
  .done_o(done_o), .rd_oe_o(rd_oe_o), .rd_data_o(rd_data_o)
);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        short_i = 1'b0;
  logic        comp_below_i;
  logic        chip_en_i = 1'b0;
  logic        byte_sel_i = 1'b0;
  logic [11:0] trial_o;
  logic        busy_o, done_o, conv_clk_en_o, rd_oe_o;
  logic [11:0] rd_data_o;
  logic [11:0] target = 12'h000;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  // Analog stand-in: keep the tested bit while the trial code does not exceed the target.
  assign comp_below_i = (trial_o <= target);

  sar_conv_ctrl dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .short_i(short_i),
    .comp_below_i(comp_below_i), .chip_en_i(chip_en_i), .byte_sel_i(byte_sel_i),
    .trial_o(trial_o), .busy_o(busy_o), .done_o(done_o),
    .conv_clk_en_o(conv_clk_en_o), .rd_oe_o(rd_oe_o), .rd_data_o(rd_data_o)
  );

  typedef struct packed {
    logic [11:0] tgt;
    logic        shrt;
    logic        bsel;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{12'hA5C, 1'b0, 1'b0},
    '{12'hA5C, 1'b0, 1'b1},
    '{12'hFFF, 1'b0, 1'b0},
    '{12'h000, 1'b0, 1'b0},
    '{12'h800, 1'b0, 1'b0},
    '{12'h7FF, 1'b0, 1'b1},
    '{12'h3C9, 1'b1, 1'b0},
    '{12'hABD, 1'b1, 1'b1},
    '{12'h001, 1'b0, 1'b1}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_result(input logic [11:0] t, input logic s);
    return s ? (t & 12'hFF0) : t;
  endfunction

  function automatic logic [11:0] exp_read(input logic [11:0] r, input logic b);
    return b ? {r[3:0], 8'h00} : r;
  endfunction

  // Starts one conversion and follows it to the end; returns the busy cycle count.
  task automatic run_conv(input logic [11:0] t, input logic s, input logic mid_start, output int n);
    logic [11:0] res;
    res = exp_result(t, s);
    @(negedge clk);
    target = t; short_i = s; start_i = 1'b1; chip_en_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after accept", int'(busy_o), 1);
    chk(trial_o == 12'h800, "R2 first trial", int'(trial_o), 'h800);
    n = 0;
    while (busy_o && n < 20) begin
      begin
        int p;
        int hi;
        p = 11 - n;
        hi = (int'(res) >> (p + 1)) << (p + 1);
        if (p >= 0)
          chk(trial_o == 12'(hi | (1 << p)), "R3 trial code", int'(trial_o), hi | (1 << p));
      end
      #1;
      chk(rd_oe_o == 1'b0 && rd_data_o == 12'h000, "R8 read blocked", int'(rd_data_o), 0);
      start_i = (mid_start && n == 3);
      n++;
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(done_o == 1'b1, "R6 done with busy fall", int'(done_o), 1);
    chk(conv_clk_en_o == 1'b0, "R6 clock gated", int'(conv_clk_en_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(busy_o == 1'b0 && done_o == 1'b0 && conv_clk_en_o == 1'b0, "R1 reset status", int'(busy_o), 0);
    chk(trial_o == 12'h000, "R1 reset register", int'(trial_o), 0);

    // Table walk
    foreach (VECS[i]) begin
      logic [11:0] r;
      r = exp_result(VECS[i].tgt, VECS[i].shrt);
      run_conv(VECS[i].tgt, VECS[i].shrt, 1'b0, n);
      if (VECS[i].shrt)
        chk(n == 8, "R7 short length", n, 8);
      else
        chk(n == 12, "R6 full length", n, 12);
      byte_sel_i = VECS[i].bsel;
      #1;
      chk(rd_oe_o == 1'b1, "R9 read enabled", int'(rd_oe_o), 1);
      chk(rd_data_o == exp_read(r, VECS[i].bsel), "R11 R4 R9 result", int'(rd_data_o),
          int'(exp_read(r, VECS[i].bsel)));
      @(negedge clk);
      chk(done_o == 1'b0, "R6 done single cycle", int'(done_o), 1'b0);
      byte_sel_i = 1'b0;
    end

    // R7 low bits zero even for an all-ones target
    run_conv(12'hFFF, 1'b1, 1'b0, n);
    #1;
    chk(rd_data_o == 12'hFF0, "R7 low nibble zero", int'(rd_data_o), 'hFF0);

    // R5: start during conversion ignored
    run_conv(12'h5A3, 1'b0, 1'b1, n);
    chk(n == 12, "R5 length kept", n, 12);
    #1;
    chk(rd_data_o == 12'h5A3, "R5 result kept", int'(rd_data_o), 'h5A3);

    // R10: chip enable low
    @(negedge clk);
    chip_en_i = 1'b0;
    #1;
    chk(rd_oe_o == 1'b0 && rd_data_o == 12'h000, "R10 chip disabled", int'(rd_data_o), 0);

    // R12: start in the done cycle
    run_conv(12'h321, 1'b0, 1'b0, n);
    #1;
    chk(rd_data_o == 12'h321, "R12 read in done cycle", int'(rd_data_o), 'h321);
    target = 12'hC0F;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1 && trial_o == 12'h800, "R12 restart accepted", int'(trial_o), 'h800);
    n = 1;
    while (busy_o && n < 20) begin
      @(negedge clk);
      if (busy_o) n++;
    end
    chk(n == 12, "R12 restart length", n, 12);
    #1;
    chk(rd_data_o == 12'hC0F, "R12 restart result", int'(rd_data_o), 'hC0F);

    // R1: reset in mid conversion
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(busy_o == 1'b0 && done_o == 1'b0 && trial_o == 12'h000, "R1 mid reset", int'(trial_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule